// File: doc/BRIEF.md
# Port-Width Beat Splitter

This block sits between an internal requester and a chip-select region whose external data port is 8, 16 or 32 bits wide. It takes one byte, word or longword access and turns it into the right number of external beats. On each beat it puts write data on the upper lanes of a 32-bit bus that the narrow port uses. On reads it gathers each beat's lanes back into one right-justified result.

The region's port code, a burst-read enable and a byte-enable mode are captured together with the request and held until the access completes. A read that is wider than the port is marked as either one burst or a set of separate single accesses. In both cases it takes the same number of beats, and a downstream timing controller uses the status flag to apply the end-of-transfer hold. The byte-enable mode decides whether read beats carry byte strobes. Write beats always carry byte-write strobes.

Top module: `sps_top`

## Requirements
- R1: Port code 00 means a 4-byte port on bits 31:0. Code 01 means a 1-byte port on bits 31:24. Codes 10 and 11 mean a 2-byte port on bits 31:16. No strobe is ever raised outside the port's lanes. Strobe bit 3 covers bits 31:24 and strobe bit 0 covers bits 7:0.
- R2: An access of N bytes (size 00 = 1, 01 = 2, 10 or 11 = 4) on a P-byte port takes exactly one beat when N <= P and N/P beats otherwise. `beat_valid_o` is high for exactly those beats.
- R3: For an oversized access, beat k has address request address + k*P. An access that fits the port keeps the request address on its single beat.
- R4: Write data is taken right-justified from `req_wdata_i`. Within the port, a byte at a lower address goes to a more significant lane. For an oversized write, beat 0 carries the most significant part.
- R5: One cycle after the last beat is acknowledged, `done_o` pulses for one cycle. On reads, `rd_data_o` then holds the N bytes assembled with the lowest address most significant, right-justified.
- R6: Write beats raise `beat_bwe_o` only on the lanes of the bytes that the beat covers, in either byte-enable mode. `beat_be_o` stays zero on writes.
- R7: On reads with byte-enable mode 0, both strobe outputs stay zero. With mode 1, `beat_be_o` is raised on the lanes that the beat covers.
- R8: `beat_burst_o` is 1 during the beats of a read wider than the port when burst reads are enabled. It is 0 for split reads, for writes and for accesses that fit the port.
- R9: A request that arrives while a transfer is in progress is ignored. Configuration changes during a transfer have no effect on it. An acknowledge while idle does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_addr_i | input | AW | Byte address, aligned to the access size |
| req_size_i | input | 2 | 00 byte, 01 word, 10/11 longword |
| req_we_i | input | 1 | 1 write, 0 read |
| req_wdata_i | input | 32 | Right-justified write data |
| cfg_port_i | input | 2 | Port width code of the region |
| cfg_burst_i | input | 1 | Run oversized reads as a burst |
| cfg_rd_be_i | input | 1 | Byte-enable mode: strobes on reads |
| beat_ack_i | input | 1 | Current beat is complete |
| beat_rdata_i | input | 32 | External bus read data |
| beat_valid_o | output | 1 | A beat is presented |
| beat_addr_o | output | AW | Beat address |
| beat_wdata_o | output | 32 | Lane-placed write data |
| beat_be_o | output | 4 | Read byte enables |
| beat_bwe_o | output | 4 | Byte-write enables |
| beat_burst_o | output | 1 | Transfer runs as a burst |
| rd_data_o | output | 32 | Assembled read result |
| done_o | output | 1 | Transfer complete pulse |

## Verification
A request is taken on a clock edge. From that edge until the edge that consumes the last acknowledge, the beat outputs show the current beat. Each acknowledged edge moves them to the next beat. `done_o` and `rd_data_o` become valid at the edge that consumes the last acknowledge and stay there for one cycle. The bench drives every input on the falling edge and samples on the next falling edge. In that way each beat is checked exactly once. The completion pulse is checked at the falling edge after the last acknowledge, and idleness one falling edge later. The bench sweeps every port code, size, aligned offset, direction, burst enable and byte-enable mode. Expected lanes and results come from a byte-addressed memory model.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int DW    = 32;
  localparam int LANES = DW / 8;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] port_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd4;
      2'b01:   return 3'd1;
      default: return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/sps_lane_map.sv
module sps_lane_map
  import sps_pkg::*;
(
  input  logic [2:0]       acc_bytes_i,
  input  logic [2:0]       port_bytes_i,
  input  logic [1:0]       addr_lo_i,
  input  logic [1:0]       beat_idx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    bus_rd_i,
  output logic [2:0]       beat_bytes_o,
  output logic [2:0]       beats_o,
  output logic [LANES-1:0] lane_mask_o,
  output logic [DW-1:0]    lane_wdata_o,
  output logic [DW-1:0]    chunk_o
);
  logic             narrow;
  logic [2:0]       off, lane_sh, chunk_sh, used;
  logic [DW-1:0]    bmask;
  logic [LANES-1:0] base_mask;

  always_comb begin
    narrow       = acc_bytes_i < port_bytes_i;
    beat_bytes_o = narrow ? acc_bytes_i : port_bytes_i;
    off          = narrow ? ({1'b0, addr_lo_i} & (port_bytes_i - 3'd1)) : 3'd0;
    // byte distance of the beat's lowest lane from bit 0
    lane_sh      = 3'd4 - off - beat_bytes_o;
    used         = ({1'b0, beat_idx_i} + 3'd1) * beat_bytes_o;
    chunk_sh     = acc_bytes_i - used;
    if (narrow || acc_bytes_i == port_bytes_i) beats_o = 3'd1;
    else if (port_bytes_i == 3'd1)              beats_o = acc_bytes_i;
    else                                        beats_o = 3'd2;
    case (beat_bytes_o)
      3'd1:    bmask = 32'h0000_00FF;
      3'd2:    bmask = 32'h0000_FFFF;
      default: bmask = 32'hFFFF_FFFF;
    endcase
    base_mask    = (4'd1 << beat_bytes_o) - 4'd1;
    lane_mask_o  = base_mask << lane_sh;
    lane_wdata_o = ((wdata_i >> {chunk_sh, 3'b000}) & bmask) << {lane_sh, 3'b000};
    chunk_o      = (bus_rd_i >> {lane_sh, 3'b000}) & bmask;
  end
endmodule

// File: rtl/sps_beat_seq.sv
module sps_beat_seq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       ack_i,
  input  logic [2:0] beats_i,
  output logic       busy_o,
  output logic [1:0] idx_o,
  output logic       last_o
);
  assign last_o = busy_o && (({1'b0, idx_o} + 3'd1) == beats_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= 2'd0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      idx_o  <= 2'd0;
    end else if (busy_o && ack_i) begin
      if (last_o) begin
        busy_o <= 1'b0;
        idx_o  <= 2'd0;
      end else begin
        idx_o  <= idx_o + 2'd1;
      end
    end
  end

  a_r2_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ({1'b0, idx_o} < beats_i));
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && idx_o == 2'd0));
endmodule

// File: rtl/sps_top.sv
module sps_top
  import sps_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [1:0]       req_size_i,
  input  logic             req_we_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic [1:0]       cfg_port_i,
  input  logic             cfg_burst_i,
  input  logic             cfg_rd_be_i,
  input  logic             beat_ack_i,
  input  logic [DW-1:0]    beat_rdata_i,
  output logic             beat_valid_o,
  output logic [AW-1:0]    beat_addr_o,
  output logic [DW-1:0]    beat_wdata_o,
  output logic [LANES-1:0] beat_be_o,
  output logic [LANES-1:0] beat_bwe_o,
  output logic             beat_burst_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             done_o
);
  logic [AW-1:0]    addr_q;
  logic [2:0]       acc_q, port_q;
  logic             we_q, burst_q, rd_be_q;
  logic [DW-1:0]    wdata_q, rd_acc_q;
  logic             busy, last, start;
  logic [1:0]       idx;
  logic [2:0]       beat_bytes, beats;
  logic [LANES-1:0] lane_mask;
  logic [DW-1:0]    lane_wdata, chunk, acc_next;
  logic [4:0]       addr_step;

  assign start = req_valid_i && !busy;

  sps_beat_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ack_i   (beat_ack_i),
    .beats_i (beats),
    .busy_o  (busy),
    .idx_o   (idx),
    .last_o  (last)
  );

  sps_lane_map u_map (
    .acc_bytes_i  (acc_q),
    .port_bytes_i (port_q),
    .addr_lo_i    (addr_q[1:0]),
    .beat_idx_i   (idx),
    .wdata_i      (wdata_q),
    .bus_rd_i     (beat_rdata_i),
    .beat_bytes_o (beat_bytes),
    .beats_o      (beats),
    .lane_mask_o  (lane_mask),
    .lane_wdata_o (lane_wdata),
    .chunk_o      (chunk)
  );

  assign addr_step    = {3'b000, idx} * {2'b00, port_q};
  assign acc_next     = (rd_acc_q << {beat_bytes, 3'b000}) | chunk;

  assign beat_valid_o = busy;
  assign beat_addr_o  = addr_q + AW'(addr_step);
  assign beat_wdata_o = (busy && we_q) ? lane_wdata : '0;
  assign beat_bwe_o   = (busy && we_q) ? lane_mask : '0;
  assign beat_be_o    = (busy && !we_q && rd_be_q) ? lane_mask : '0;
  assign beat_burst_o = busy && !we_q && burst_q && (acc_q > port_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      acc_q     <= 3'd1;
      port_q    <= 3'd4;
      we_q      <= 1'b0;
      burst_q   <= 1'b0;
      rd_be_q   <= 1'b0;
      wdata_q   <= '0;
      rd_acc_q  <= '0;
      rd_data_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start) begin
        addr_q   <= req_addr_i;
        acc_q    <= size_bytes(req_size_i);
        port_q   <= port_bytes(cfg_port_i);
        we_q     <= req_we_i;
        burst_q  <= cfg_burst_i;
        rd_be_q  <= cfg_rd_be_i;
        wdata_q  <= req_wdata_i;
        rd_acc_q <= '0;
      end else if (busy && beat_ack_i) begin
        rd_acc_q <= acc_next;
        if (last) begin
          done_o <= 1'b1;
          if (!we_q) rd_data_o <= acc_next;
        end
      end
    end
  end

  logic [LANES-1:0] port_lanes;
  assign port_lanes = (port_q == 3'd1) ? 4'b1000 : (port_q == 3'd2) ? 4'b1100 : 4'b1111;

  a_r1_port_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> (((beat_be_o | beat_bwe_o) & ~port_lanes) == '0));
  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_ack_i && !last) |=> (beat_addr_o == $past(beat_addr_o) + AW'(port_q)));
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|beat_be_o) |-> !(|beat_bwe_o));
  a_r8_burst_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_burst_o |-> (beat_valid_o && beat_bwe_o == '0));
endmodule

// File: tb/sps_top_tb.sv
module sps_top_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  cfg_port = '0;
  logic        cfg_burst = 1'b0;
  logic        cfg_rd_be = 1'b0;
  logic        beat_ack = 1'b0;
  logic [31:0] beat_rdata = '0;
  logic        beat_valid, beat_burst, done;
  logic [31:0] beat_addr, beat_wdata, rd_data;
  logic [3:0]  beat_be, beat_bwe;

  int total = 0;
  int fails = 0;
  int xfer_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  sps_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .cfg_port_i(cfg_port), .cfg_burst_i(cfg_burst), .cfg_rd_be_i(cfg_rd_be),
    .beat_ack_i(beat_ack), .beat_rdata_i(beat_rdata), .beat_valid_o(beat_valid),
    .beat_addr_o(beat_addr), .beat_wdata_o(beat_wdata), .beat_be_o(beat_be),
    .beat_bwe_o(beat_bwe), .beat_burst_o(beat_burst), .rd_data_o(rd_data), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_b(input logic [31:0] a);
    return a[7:0] ^ 8'h5A ^ {a[11:8], 4'h3};
  endfunction

  function automatic int pbytes(input logic [1:0] code);
    return (code == 2'b00) ? 4 : (code == 2'b01) ? 1 : 2;
  endfunction

  function automatic logic [31:0] bus_for(input logic [31:0] ba, input int p);
    logic [31:0] bus, base_al;
    base_al = ba - (ba % p);
    for (int j = 0; j < 4; j++) bus[31-8*j -: 8] = (j < p) ? mem_b(base_al + j) : 8'hEE;
    return bus;
  endfunction

  task automatic run_xfer(input logic [1:0] ps, input logic [1:0] sz, input int off,
                          input logic we, input logic bst, input logic bem);
    int n, p, w, nb;
    logic [31:0] addr, wd, ba, ewd, lm32, eres;
    logic [3:0]  emask;
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    p = pbytes(ps);
    addr = 32'h0000_1240 + off;
    wd = 32'h8C3F_A569 ^ (xfer_cnt * 32'h0107_0B0D);
    xfer_cnt++;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_size = sz; req_we = we; req_wdata = wd;
    cfg_port = ps; cfg_burst = bst; cfg_rd_be = bem;
    @(negedge clk);
    req_valid = 1'b0;
    w = (n < p) ? n : p;
    nb = n / w;
    for (int k = 0; k < nb; k++) begin
      ba = addr + k * p;
      emask = '0; ewd = '0; lm32 = '0;
      for (int b = 0; b < w; b++) begin
        int j, bi;
        j = (ba + b) % p;
        bi = n - 1 - (ba + b - addr);
        emask[3-j] = 1'b1;
        ewd[31-8*j -: 8] = wd[8*bi +: 8];
        lm32[31-8*j -: 8] = 8'hFF;
      end
      chk("R2 beat_valid", {31'b0, beat_valid}, 32'd1);
      chk("R3 beat_addr", beat_addr, ba);
      chk("R5 done low mid-transfer", {31'b0, done}, 32'd0);
      chk("R1 lanes inside port", {28'b0, (beat_be | beat_bwe) & ~((p == 1) ? 4'b1000 : (p == 2) ? 4'b1100 : 4'b1111)}, 32'd0);
      chk("R6 bwe", {28'b0, beat_bwe}, we ? {28'b0, emask} : 32'd0);
      chk("R7 be", {28'b0, beat_be}, (!we && bem) ? {28'b0, emask} : 32'd0);
      chk("R8 burst flag", {31'b0, beat_burst}, (!we && n > p && bst) ? 32'd1 : 32'd0);
      if (we) chk("R4 write lanes", beat_wdata & lm32, ewd);
      beat_rdata = bus_for(ba, p);
      beat_ack = 1'b1;
      @(negedge clk);
      beat_ack = 1'b0;
    end
    chk("R5 done pulse", {31'b0, done}, 32'd1);
    chk("R2 no extra beat", {31'b0, beat_valid}, 32'd0);
    if (!we) begin
      eres = '0;
      for (int b = 0; b < n; b++) eres = (eres << 8) | {24'b0, mem_b(addr + b)};
      chk("R5 read result", rd_data, eres);
    end
    @(negedge clk);
    chk("R5 done one cycle", {31'b0, done}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : stim
    logic [31:0] ba;
    repeat (3) @(negedge clk);
    chk("R2 reset valid", {31'b0, beat_valid}, 32'd0);
    chk("R5 reset done", {31'b0, done}, 32'd0);
    chk("R5 reset data", rd_data, 32'd0);
    chk("R6 reset strobes", {24'b0, beat_be, beat_bwe}, 32'd0);
    rst_n = 1'b1;

    for (int ps = 0; ps < 4; ps++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++)
          for (int we = 0; we < 2; we++)
            for (int bst = 0; bst < 2; bst++)
              for (int bem = 0; bem < 2; bem++)
                if (off % ((sz == 0) ? 1 : (sz == 1) ? 2 : 4) == 0)
                  run_xfer(2'(ps), 2'(sz), off, 1'(we), 1'(bst), 1'(bem));

    // R9: request and config changes while busy must not disturb the transfer
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_1300; req_size = 2'b10; req_we = 1'b0;
    cfg_port = 2'b01; cfg_burst = 1'b1; cfg_rd_be = 1'b1;
    @(negedge clk);
    req_addr = 32'h2000_0000; cfg_port = 2'b00; cfg_rd_be = 1'b0; cfg_burst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      ba = 32'h0000_1300 + k;
      chk("R9 addr unaffected", beat_addr, ba);
      chk("R9 strobe lane kept", {28'b0, beat_be}, 32'h8);
      chk("R9 burst kept", {31'b0, beat_burst}, 32'd1);
      beat_rdata = bus_for(ba, 1);
      beat_ack = 1'b1;
      @(negedge clk);
      beat_ack = 1'b0;
    end
    req_valid = 1'b0;
    chk("R9 done", {31'b0, done}, 32'd1);
    chk("R9 result", rd_data, {mem_b(32'h1300), mem_b(32'h1301), mem_b(32'h1302), mem_b(32'h1303)});

    // R9: acknowledge while idle
    @(negedge clk);
    beat_ack = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk("R9 idle ack valid", {31'b0, beat_valid}, 32'd0);
      chk("R9 idle ack done", {31'b0, done}, 32'd0);
    end
    beat_ack = 1'b0;
    run_xfer(2'b01, 2'b10, 0, 1'b0, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule